// File: doc/BRIEF.md
# SIMT Warp Reconvergence Controller

This block steers one 32-lane warp that shares a single program counter and a mask of enabled lanes. When the lanes of the warp resolve a conditional branch differently, the controller runs the taken lanes first. It records the other lanes, the address where they resume and the address where both groups meet again on a stack of nesting levels. Lanes outside the current path stay disabled, so every instruction issued on that path is a no-operation for them. When the running path reaches the meeting address, the controller switches to the waiting path. When both paths have arrived there, it restores the whole group and continues with all of those lanes together.

An issue stage presents one operation per cycle: a plain step to a next address, a branch (per-lane outcome, taken address, fall-through address, meeting address), or a retirement of the running lanes. The controller answers with the PC and mask to issue, plus an `issue` qualifier that is low in any cycle it spends switching paths. Loops whose lanes leave on different iterations fit in a single level: leaving lanes wait at the loop exit until the last lane leaves. Retired lanes drop out of every saved mask, and the warp reports completion once no lane is left.

The control is a four-state machine. **IDLE** is the state after reset. **RUN** is the working state. **DONE** means every lane has retired. **FAULT** means a new nesting level was needed while the stack was full. The *launch* transition goes from IDLE, DONE or FAULT to RUN. The *retire-all* transition goes from RUN to DONE, taken when the mask is empty and no level is saved. The *overflow* transition goes from RUN to FAULT. Inside RUN, each cycle is either an issue cycle or a rejoin cycle. A rejoin cycle happens when the mask is empty, or when a level is saved and the PC equals that level's meeting address.

Top module: `simt_warp_ctrl`

## Requirements
- R1: After reset the outputs are pc=0, active_mask=0, issue=0, done=0, stack_full=0 (IDLE). A launch in IDLE, DONE or FAULT loads launch_pc and launch_mask on the next edge, enters RUN and empties the stack.
- R2: In an issue cycle, op=1 (step) moves pc to nxt_pc and leaves the mask unchanged.
- R3: op=2 (branch) uses lane_taken bit i for lane i. Only bits of enabled lanes count. If all enabled lanes agree, pc becomes tgt_pc (taken) or nxt_pc (not taken), the mask is kept and no level is saved.
- R4: A branch that splits the enabled lanes, where neither tgt_pc nor nxt_pc equals join_pc, saves a level. On the next edge pc=tgt_pc and the mask becomes the taken lanes. The mask never gains lanes on a branch.
- R5: When pc equals the innermost level's join address and that level still holds a waiting path, one rejoin cycle (issue=0) follows. The next edge gives pc=saved fall-through address and mask=the not-taken lanes.
- R6: When pc equals the innermost join address and no path waits, the level is removed. pc becomes the join address and the mask becomes the mask held before the split, minus retired lanes.
- R7: Splits nest. Each level unwinds in reverse order of creation, back to the outermost mask.
- R8: If one side of a split targets join_pc, that side is not run, and its lanes wait at the join. If the innermost level already has that join address, no new level is saved, so any number of loop iterations uses one level.
- R9: A split that needs a new level while DEPTH levels are held enters FAULT. stack_full=1, issue=0, and pc and mask freeze until a launch.
- R10: op=3 (exit) retires the enabled lanes. The mask becomes 0 and those lanes are removed from every saved mask.
- R11: An empty mask with no saved level leads to DONE: done=1, active_mask=0, issue=0. At most one of issue, done and stack_full is high.
- R12: op is ignored whenever issue=0 (IDLE, DONE, FAULT and rejoin cycles).
- R13: A launch from DONE or FAULT restarts the warp with done=0 and stack_full=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch | input | 1 | Start a warp (honoured outside RUN) |
| launch_pc | input | AW | First PC of the warp |
| launch_mask | input | LANES | Lanes present at launch |
| op | input | 2 | 0 none, 1 step, 2 branch, 3 exit |
| lane_taken | input | LANES | Per-lane branch outcome |
| tgt_pc | input | AW | Branch taken address |
| nxt_pc | input | AW | Step / fall-through address |
| join_pc | input | AW | Meeting address of the branch |
| pc | output | AW | PC to issue |
| active_mask | output | LANES | Enabled lanes |
| issue | output | 1 | Operation accepted this cycle |
| done | output | 1 | All lanes retired |
| stack_full | output | 1 | Nesting overflow fault |

## Verification
The checker examines these properties on every cycle:
- the step result;
- that a branch never enables new lanes;
- that an exit clears the mask;
- the freeze in FAULT and the hold in DONE;
- the restart values;
- that at most one of the three flags is high.

Other behaviour depends on earlier history and only the bench scenarios can show it:
- restoring the saved fall-through path and the pre-split mask, in the right nesting order;
- the single-level handling of a many-iteration loop;
- removing retired lanes from masks saved several levels down;
- the exact cycle at which a full stack faults.

The bench compares every cycle against a queue-based model.

// File: rtl/simt_pkg.sv
`timescale 1ns/1ps
package simt_pkg;
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_STEP   = 2'd1,
        OP_BRANCH = 2'd2,
        OP_EXIT   = 2'd3
    } warp_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } warp_st_e;
endpackage

// File: rtl/simt_branch_split.sv
`timescale 1ns/1ps
module simt_branch_split #(
    parameter int LANES = 32,
    parameter int AW    = 32
) (
    input  logic [LANES-1:0] act_mask,
    input  logic [LANES-1:0] lane_taken,
    input  logic [AW-1:0]    tgt_pc,
    input  logic [AW-1:0]    nxt_pc,
    input  logic [AW-1:0]    join_pc,
    input  logic [AW-1:0]    top_rpc,
    input  logic             stk_empty,
    output logic [AW-1:0]    go_pc,
    output logic [LANES-1:0] go_mask,
    output logic             need_push,
    output logic [LANES-1:0] pend_mask,
    output logic             pend_vld
);
    logic [LANES-1:0] t_m;
    logic [LANES-1:0] n_m;
    logic             split;
    logic             same_level;
    logic             t_join;
    logic             n_join;

    always_comb begin
        t_m        = act_mask & lane_taken;
        n_m        = act_mask & ~lane_taken;
        split      = (t_m != '0) && (n_m != '0);
        same_level = !stk_empty && (top_rpc == join_pc);
        t_join     = (tgt_pc == join_pc);
        n_join     = (nxt_pc == join_pc);
        go_pc      = nxt_pc;
        go_mask    = act_mask;
        need_push  = 1'b0;
        pend_mask  = n_m;
        pend_vld   = 1'b0;
        if (!split) begin
            go_pc = (t_m != '0) ? tgt_pc : nxt_pc;
        end else if (t_join && n_join) begin
            go_pc = join_pc;
        end else if (n_join) begin
            go_pc     = tgt_pc;
            go_mask   = t_m;
            need_push = !same_level;
        end else if (t_join) begin
            go_pc     = nxt_pc;
            go_mask   = n_m;
            need_push = !same_level;
        end else begin
            go_pc     = tgt_pc;
            go_mask   = t_m;
            need_push = 1'b1;
            pend_vld  = 1'b1;
        end
    end
endmodule

// File: rtl/simt_recon_stack.sv
`timescale 1ns/1ps
module simt_recon_stack #(
    parameter int LANES = 32,
    parameter int AW    = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic             take_pend,
    input  logic [LANES-1:0] kill_mask,
    input  logic [AW-1:0]    push_rpc,
    input  logic [LANES-1:0] push_join,
    input  logic [AW-1:0]    push_ppc,
    input  logic [LANES-1:0] push_pmask,
    input  logic             push_pv,
    output logic [AW-1:0]    top_rpc,
    output logic [LANES-1:0] top_join,
    output logic [AW-1:0]    top_ppc,
    output logic [LANES-1:0] top_pmask,
    output logic             top_pv,
    output logic             empty,
    output logic             full
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [CW-1:0]    cnt_q;
    logic [IW-1:0]    top_ix;
    logic [AW-1:0]    rpc_a   [DEPTH];
    logic [LANES-1:0] join_a  [DEPTH];
    logic [AW-1:0]    ppc_a   [DEPTH];
    logic [LANES-1:0] pmask_a [DEPTH];
    logic             pv_a    [DEPTH];

    assign empty  = (cnt_q == '0);
    assign full   = (cnt_q == DEPTH_C);
    assign top_ix = IW'(cnt_q - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + CW'(1);
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_lvl
        localparam logic [CW-1:0] MY_SLOT = CW'(e);
        localparam logic [IW-1:0] MY_IX   = IW'(e);
        logic [AW-1:0]    rpc_q;
        logic [LANES-1:0] join_q;
        logic [AW-1:0]    ppc_q;
        logic [LANES-1:0] pmask_q;
        logic             pv_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rpc_q   <= '0;
                join_q  <= '0;
                ppc_q   <= '0;
                pmask_q <= '0;
                pv_q    <= 1'b0;
            end else if (push && !full && (cnt_q == MY_SLOT)) begin
                rpc_q   <= push_rpc;
                join_q  <= push_join;
                ppc_q   <= push_ppc;
                pmask_q <= push_pmask;
                pv_q    <= push_pv;
            end else begin
                join_q  <= join_q & ~kill_mask;
                pmask_q <= pmask_q & ~kill_mask;
                if (take_pend && !empty && (top_ix == MY_IX)) begin
                    pv_q <= 1'b0;
                end
            end
        end

        assign rpc_a[e]   = rpc_q;
        assign join_a[e]  = join_q;
        assign ppc_a[e]   = ppc_q;
        assign pmask_a[e] = pmask_q;
        assign pv_a[e]    = pv_q;
    end

    assign top_rpc   = rpc_a[top_ix];
    assign top_join  = join_a[top_ix];
    assign top_ppc   = ppc_a[top_ix];
    assign top_pmask = pmask_a[top_ix];
    assign top_pv    = pv_a[top_ix];
endmodule

// File: rtl/simt_warp_ctrl.sv
`timescale 1ns/1ps
module simt_warp_ctrl #(
    parameter int LANES = 32,
    parameter int AW    = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [AW-1:0]    launch_pc,
    input  logic [LANES-1:0] launch_mask,
    input  logic [1:0]       op,
    input  logic [LANES-1:0] lane_taken,
    input  logic [AW-1:0]    tgt_pc,
    input  logic [AW-1:0]    nxt_pc,
    input  logic [AW-1:0]    join_pc,
    output logic [AW-1:0]    pc,
    output logic [LANES-1:0] active_mask,
    output logic             issue,
    output logic             done,
    output logic             stack_full
);
    import simt_pkg::*;

    warp_st_e         state_q, state_d;
    logic [AW-1:0]    pc_q, pc_d;
    logic [LANES-1:0] mask_q, mask_d;
    warp_op_e         op_e;
    logic             rejoin;

    logic             s_clr, s_push, s_pop, s_take;
    logic [LANES-1:0] s_kill;
    logic [AW-1:0]    top_rpc, top_ppc;
    logic [LANES-1:0] top_join, top_pmask;
    logic             top_pv, stk_empty, stk_full;

    logic [AW-1:0]    go_pc;
    logic [LANES-1:0] go_mask, pend_mask;
    logic             need_push, pend_vld;

    simt_branch_split #(.LANES(LANES), .AW(AW)) u_split (
        .act_mask  (mask_q),
        .lane_taken(lane_taken),
        .tgt_pc    (tgt_pc),
        .nxt_pc    (nxt_pc),
        .join_pc   (join_pc),
        .top_rpc   (top_rpc),
        .stk_empty (stk_empty),
        .go_pc     (go_pc),
        .go_mask   (go_mask),
        .need_push (need_push),
        .pend_mask (pend_mask),
        .pend_vld  (pend_vld)
    );

    simt_recon_stack #(.LANES(LANES), .AW(AW), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (s_clr),
        .push      (s_push),
        .pop       (s_pop),
        .take_pend (s_take),
        .kill_mask (s_kill),
        .push_rpc  (join_pc),
        .push_join (mask_q),
        .push_ppc  (nxt_pc),
        .push_pmask(pend_mask),
        .push_pv   (pend_vld),
        .top_rpc   (top_rpc),
        .top_join  (top_join),
        .top_ppc   (top_ppc),
        .top_pmask (top_pmask),
        .top_pv    (top_pv),
        .empty     (stk_empty),
        .full      (stk_full)
    );

    assign op_e   = warp_op_e'(op);
    assign rejoin = (mask_q == '0) || (!stk_empty && (pc_q == top_rpc));

    // next-state and stack control
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        mask_d  = mask_q;
        s_clr   = 1'b0;
        s_push  = 1'b0;
        s_pop   = 1'b0;
        s_take  = 1'b0;
        s_kill  = '0;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAULT: begin
                if (launch) begin
                    state_d = ST_RUN;
                    pc_d    = launch_pc;
                    mask_d  = launch_mask;
                    s_clr   = 1'b1;
                end
            end
            ST_RUN: begin
                if (rejoin) begin
                    if (stk_empty) begin
                        state_d = ST_DONE;
                    end else if (top_pv) begin
                        pc_d   = top_ppc;
                        mask_d = top_pmask;
                        s_take = 1'b1;
                    end else begin
                        pc_d   = top_rpc;
                        mask_d = top_join;
                        s_pop  = 1'b1;
                    end
                end else begin
                    unique case (op_e)
                        OP_STEP: pc_d = nxt_pc;
                        OP_BRANCH: begin
                            if (need_push && stk_full) begin
                                state_d = ST_FAULT;
                            end else begin
                                pc_d   = go_pc;
                                mask_d = go_mask;
                                s_push = need_push;
                            end
                        end
                        OP_EXIT: begin
                            mask_d = '0;
                            s_kill = mask_q;
                        end
                        OP_NONE: ;
                    endcase
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '0;
            mask_q <= '0;
        end else begin
            pc_q   <= pc_d;
            mask_q <= mask_d;
        end
    end

    // outputs
    always_comb begin
        pc          = pc_q;
        active_mask = mask_q;
        issue       = (state_q == ST_RUN) && !rejoin;
        done        = (state_q == ST_DONE);
        stack_full  = (state_q == ST_FAULT);
    end
endmodule

// File: rtl/simt_warp_ctrl_chk.sv
`timescale 1ns/1ps
module simt_warp_ctrl_chk #(
    parameter int LANES = 32,
    parameter int AW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             launch,
    input logic [AW-1:0]    launch_pc,
    input logic [LANES-1:0] launch_mask,
    input logic [1:0]       op,
    input logic [AW-1:0]    nxt_pc,
    input logic [AW-1:0]    pc,
    input logic [LANES-1:0] active_mask,
    input logic             issue,
    input logic             done,
    input logic             stack_full
);
    // R2
    step_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue && op == 2'd1 |=> pc == $past(nxt_pc) && active_mask == $past(active_mask));

    // R4
    branch_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue && op == 2'd2 |=> (active_mask & ~$past(active_mask)) == '0);

    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_full && !launch |=> stack_full && $stable(pc) && $stable(active_mask));

    // R10
    exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue && op == 2'd3 |=> active_mask == '0);

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> active_mask == '0 && !issue);

    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({issue, done, stack_full}));

    // R12
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !launch |=> done && $stable(pc));

    // R13
    relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || stack_full) && launch |=>
            pc == $past(launch_pc) && active_mask == $past(launch_mask) && !done && !stack_full);
endmodule

bind simt_warp_ctrl simt_warp_ctrl_chk #(.LANES(LANES), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .launch_pc  (launch_pc),
    .launch_mask(launch_mask),
    .op         (op),
    .nxt_pc     (nxt_pc),
    .pc         (pc),
    .active_mask(active_mask),
    .issue      (issue),
    .done       (done),
    .stack_full (stack_full)
);

// File: tb/test_simt_warp_ctrl.sv
`timescale 1ns/1ps
module test_simt_warp_ctrl;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch = 1'b0;
    logic [31:0] launch_pc = '0;
    logic [31:0] launch_mask = '0;
    logic [1:0]  op = 2'd0;
    logic [31:0] lane_taken = '0;
    logic [31:0] tgt_pc = '0;
    logic [31:0] nxt_pc = '0;
    logic [31:0] join_pc = '0;
    logic [31:0] pc;
    logic [31:0] active_mask;
    logic        issue, done, stack_full;

    simt_warp_ctrl i_simt_warp_ctrl (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_pc(launch_pc),
        .launch_mask(launch_mask), .op(op), .lane_taken(lane_taken),
        .tgt_pc(tgt_pc), .nxt_pc(nxt_pc), .join_pc(join_pc), .pc(pc),
        .active_mask(active_mask), .issue(issue), .done(done), .stack_full(stack_full)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference: a queue of saved levels
    typedef struct {
        logic [31:0] rpc;
        logic [31:0] jm;
        logic [31:0] ppc;
        logic [31:0] pm;
        bit          pv;
    } lvl_t;
    lvl_t        stk[$];
    int          m_st = 0;          // 0 idle, 1 run, 2 done, 3 fault
    logic [31:0] m_pc = '0;
    logic [31:0] m_mask = '0;

    function automatic bit m_rejoin();
        if (m_st != 1) return 1'b0;
        if (m_mask == 0) return 1'b1;
        return (stk.size() > 0) && (m_pc == stk[stk.size()-1].rpc);
    endfunction

    task automatic m_branch();
        logic [31:0] tk, st;
        bit tj, nj, same, push;
        lvl_t lv;
        tk = m_mask & lane_taken;
        st = m_mask & ~lane_taken;
        if (tk == 0) begin m_pc = nxt_pc; return; end
        if (st == 0) begin m_pc = tgt_pc; return; end
        tj = (tgt_pc == join_pc);
        nj = (nxt_pc == join_pc);
        if (tj && nj) begin m_pc = join_pc; return; end
        same = (stk.size() > 0) && (stk[stk.size()-1].rpc == join_pc);
        push = !(tj || nj) || !same;
        if (push && stk.size() == DEPTH) begin m_st = 3; return; end
        lv.rpc = join_pc; lv.jm = m_mask; lv.ppc = nxt_pc; lv.pm = st; lv.pv = 1'b0;
        if (!tj && !nj) begin lv.pv = 1'b1; m_pc = tgt_pc; m_mask = tk; end
        else if (nj) begin m_pc = tgt_pc; m_mask = tk; end
        else begin m_pc = nxt_pc; m_mask = st; end
        if (push) stk.push_back(lv);
    endtask

    task automatic model_step();
        if (m_st != 1) begin
            if (launch) begin
                m_st = 1; m_pc = launch_pc; m_mask = launch_mask; stk.delete();
            end
        end else if (m_rejoin()) begin
            if (stk.size() == 0) begin
                m_st = 2;
            end else if (stk[stk.size()-1].pv) begin
                m_pc = stk[stk.size()-1].ppc;
                m_mask = stk[stk.size()-1].pm;
                stk[stk.size()-1].pv = 1'b0;
            end else begin
                m_pc = stk[stk.size()-1].rpc;
                m_mask = stk[stk.size()-1].jm;
                void'(stk.pop_back());
            end
        end else begin
            case (op)
                2'd1: m_pc = nxt_pc;
                2'd2: m_branch();
                2'd3: begin
                    foreach (stk[i]) begin
                        stk[i].jm = stk[i].jm & ~m_mask;
                        stk[i].pm = stk[i].pm & ~m_mask;
                    end
                    m_mask = '0;
                end
                default: ;
            endcase
        end
    endtask

    task automatic compare();
        bit e_iss, e_done, e_full;
        e_iss  = (m_st == 1) && !m_rejoin();
        e_done = (m_st == 2);
        e_full = (m_st == 3);
        total++;
        if (pc !== m_pc || active_mask !== m_mask || issue !== e_iss ||
            done !== e_done || stack_full !== e_full) begin
            bad++;
            $display("FAIL %s model: actual pc=%h mask=%h iss=%b done=%b full=%b expected pc=%h mask=%h iss=%b done=%b full=%b",
                     cur_req, pc, active_mask, issue, done, stack_full,
                     m_pc, m_mask, e_iss, e_done, e_full);
        end
    endtask

    task automatic want(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [1:0] o, input logic [31:0] tk, input logic [31:0] tg,
                       input logic [31:0] nx, input logic [31:0] jn);
        op = o; lane_taken = tk; tgt_pc = tg; nxt_pc = nx; join_pc = jn;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        op = 2'd0;
        launch = 1'b0;
    endtask

    task automatic start(input logic [31:0] p, input logic [31:0] m);
        launch = 1'b1; launch_pc = p; launch_mask = m;
        cyc(2'd0, '0, '0, '0, '0);
    endtask

    task automatic drain();
        for (int k = 0; k < 40; k++) begin
            if (done) break;
            if (issue) cyc(2'd3, '0, '0, '0, '0);
            else cyc(2'd0, '0, '0, '0, '0);
        end
        want("R11 drain done", {31'd0, done}, 32'd1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
            $display("  test done: total=%0d bad=%0d", total + 1, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        compare();
        want("R1 reset pc", pc, 32'h0);
        want("R1 reset flags", {28'd0, issue, done, stack_full, active_mask != 0}, 32'h0);

        cur_req = "R12";
        cyc(2'd1, '0, '0, 32'h40, '0);
        want("R12 idle ignores step", pc, 32'h0);

        cur_req = "R1";
        start(32'h0FC, 32'hFFFF_FFFF);
        want("R1 launch pc", pc, 32'h0FC);
        want("R1 launch issue", {31'd0, issue}, 32'd1);

        cur_req = "R2";
        cyc(2'd1, '0, '0, 32'h100, '0);
        want("R2 step pc", pc, 32'h100);

        cur_req = "R3";
        cyc(2'd2, 32'hFFFF_FFFF, 32'h200, 32'h104, 32'h999);
        want("R3 uniform taken pc", pc, 32'h200);

        cur_req = "R4";
        cyc(2'd2, 32'h0000_FFFF, 32'h300, 32'h204, 32'h400);
        want("R4 split pc", pc, 32'h300);
        want("R4 split mask", active_mask, 32'h0000_FFFF);

        cur_req = "R3";
        cyc(2'd2, 32'hABCD_0000, 32'h777, 32'h304, 32'h888);
        want("R3 inactive bits ignored pc", pc, 32'h304);
        want("R3 inactive bits ignored mask", active_mask, 32'h0000_FFFF);

        cur_req = "R5";
        cyc(2'd1, '0, '0, 32'h400, '0);
        want("R5 rejoin cycle issue", {31'd0, issue}, 32'd0);
        cur_req = "R12";
        cyc(2'd1, '0, '0, 32'hDEAD, '0);
        want("R5 pending path pc", pc, 32'h204);
        want("R5 pending path mask", active_mask, 32'hFFFF_0000);

        cur_req = "R6";
        cyc(2'd1, '0, '0, 32'h400, '0);
        cyc(2'd0, '0, '0, '0, '0);
        want("R6 pop pc", pc, 32'h400);
        want("R6 pop mask", active_mask, 32'hFFFF_FFFF);
        want("R6 issue after pop", {31'd0, issue}, 32'd1);
        drain();

        cur_req = "R7";
        start(32'h100, 32'hFFFF_FFFF);
        cyc(2'd2, 32'h0000_FFFF, 32'h110, 32'h180, 32'h1F0);
        cyc(2'd2, 32'h0000_00FF, 32'h120, 32'h140, 32'h160);
        want("R7 inner mask", active_mask, 32'h0000_00FF);
        cur_req = "R3";
        cyc(2'd2, 32'hFFFF_FF00, 32'h300, 32'h124, 32'h999);
        want("R3 uniform not-taken pc", pc, 32'h124);
        cur_req = "R7";
        cyc(2'd1, '0, '0, 32'h160, '0);
        cyc(2'd0, '0, '0, '0, '0);
        want("R7 inner other side", active_mask, 32'h0000_FF00);
        cyc(2'd1, '0, '0, 32'h160, '0);
        cyc(2'd0, '0, '0, '0, '0);
        want("R7 inner join mask", active_mask, 32'h0000_FFFF);
        cyc(2'd1, '0, '0, 32'h1F0, '0);
        cyc(2'd0, '0, '0, '0, '0);
        want("R7 outer other side", active_mask, 32'hFFFF_0000);
        cyc(2'd1, '0, '0, 32'h1F0, '0);
        cyc(2'd0, '0, '0, '0, '0);
        want("R7 outer join pc", pc, 32'h1F0);
        want("R7 outer join mask", active_mask, 32'hFFFF_FFFF);
        drain();

        cur_req = "R8";
        start(32'h500, 32'hFFFF_FFFF);
        for (int i = 1; i <= 10; i++) begin
            cyc(2'd1, '0, '0, 32'h504, '0);
            cyc(2'd2, 32'hFFFF_FFFF << (2 * i), 32'h500, 32'h508, 32'h508);
        end
        want("R8 loop mask", active_mask, 32'hFFF0_0000);
        want("R8 no overflow", {31'd0, stack_full}, 32'd0);
        cyc(2'd1, '0, '0, 32'h504, '0);
        cyc(2'd2, 32'h0, 32'h500, 32'h508, 32'h508);
        cyc(2'd0, '0, '0, '0, '0);
        want("R8 loop exit pc", pc, 32'h508);
        want("R8 loop exit mask", active_mask, 32'hFFFF_FFFF);
        drain();

        cur_req = "R10";
        start(32'h600, 32'hFFFF_FFFF);
        cyc(2'd2, 32'h0000_00FF, 32'h700, 32'h604, 32'h800);
        cyc(2'd3, '0, '0, '0, '0);
        want("R10 exit mask", active_mask, 32'h0);
        cyc(2'd0, '0, '0, '0, '0);
        want("R10 pending after exit", active_mask, 32'hFFFF_FF00);
        cyc(2'd1, '0, '0, 32'h800, '0);
        cyc(2'd0, '0, '0, '0, '0);
        want("R10 join drops retired", active_mask, 32'hFFFF_FF00);
        cur_req = "R11";
        cyc(2'd3, '0, '0, '0, '0);
        cyc(2'd0, '0, '0, '0, '0);
        want("R11 done", {31'd0, done}, 32'd1);
        cur_req = "R12";
        cyc(2'd1, '0, '0, 32'h900, '0);
        want("R12 done ignores step", pc, 32'h800);
        cur_req = "R13";
        start(32'hA00, 32'h0000_000F);
        want("R13 relaunch pc", pc, 32'hA00);
        want("R13 relaunch mask", active_mask, 32'h0000_000F);
        want("R13 relaunch done", {31'd0, done}, 32'd0);
        drain();

        cur_req = "R9";
        start(32'h1000, 32'hFFFF_FFFF);
        for (int k = 0; k <= DEPTH; k++) begin
            cyc(2'd2, 32'hFFFF_FFFF >> (k + 1), 32'h2000 + 32'(k) * 32'h100,
                32'h3000 + 32'(k) * 32'h100, 32'h4000 + 32'(k) * 32'h100);
        end
        want("R9 overflow flag", {31'd0, stack_full}, 32'd1);
        want("R9 frozen pc", pc, 32'h2700);
        want("R9 frozen mask", active_mask, 32'h00FF_FFFF);
        cur_req = "R12";
        cyc(2'd1, '0, '0, 32'h5555, '0);
        want("R12 fault ignores step", pc, 32'h2700);
        cur_req = "R13";
        start(32'hB00, 32'hFFFF_FFFF);
        want("R13 fault cleared", {31'd0, stack_full}, 32'd0);
        want("R13 restart pc", pc, 32'hB00);
        drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule